// File: doc/BRIEF.md
# Composite Raster Sync Generator

This block produces the raster timing for a monochrome composite television output from a 50 MHz timing clock, where one clock lasts 20 ns. Two timing sets are held in the block. A 50 Hz set uses 3200-clock lines and 312-line frames. A 60 Hz set uses 3175-clock lines and 262-line frames. A one-bit standard-select input picks between them at run time.

Downstream video logic receives the horizontal clock position and the line number. It also receives horizontal-active, vertical-active and display-enable flags. A single active-low composite sync merges the horizontal and vertical sync. One-clock strobes mark the first clock of every line and of every frame.

The standard-select input is taken only on the first clock of a frame. A frame is therefore always built from one timing set from start to end. All flags are registered, and they describe the counter values shown in the same cycle.

Top module: `comp_sync_gen`

## Requirements
- R1: While `rst_n` is low, both counters read 0, `csync_n_o` is 1, and every flag and strobe output is 0. This holds at once, without waiting for a clock edge.
- R2: The clock counter rises by one on every clock. It returns to 0 after 3200 clocks when select is 0 (50 Hz) and after 3175 clocks when select is 1 (60 Hz). The line counter rises by one each time the clock counter returns to 0.
- R3: The line counter returns to 0 after 312 lines when select is 0 and after 262 lines when select is 1.
- R4: Horizontal sync is low at clock positions 0 to 234 of every line, in both standards.
- R5: `csync_n_o` is low when horizontal sync is low or when the line number is 0 to 4. Otherwise it is high.
- R6: `h_active_o` is high from position 435 to 3034 when select is 0. This is a 200-clock back porch after sync, then 2600 active clocks. It is high from position 470 to 3099 when select is 1, which is a 235-clock back porch, then 2630 active clocks. A window that would run past the end of the line stops at the line end.
- R7: `v_active_o` is high on lines 38 to 293 when select is 0 and on lines 6 to 261 when select is 1.
- R8: `disp_en_o` is high exactly when both `h_active_o` and `v_active_o` are high.
- R9: `line_start_o` is high for one clock, when the clock counter reads 0. `frame_start_o` is high for one clock, when both counters read 0. Neither is high in the cycle directly after reset is released.
- R10: The select input is taken on the clock edge that leaves position 0 of line 0. This includes the first edge after reset. A change at any other time has no effect until the next frame begins.
- R11: From the second clock after reset is released, every flag output matches the counter values shown in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_sel_i | input | 1 | Standard select: 0 = 50 Hz set, 1 = 60 Hz set |
| h_cnt_o | output | HW (12) | Clock position within the line |
| v_cnt_o | output | VW (9) | Line number within the frame |
| h_active_o | output | 1 | Inside the horizontal active window |
| v_active_o | output | 1 | Inside the vertical active window |
| disp_en_o | output | 1 | Display enable, both windows active |
| csync_n_o | output | 1 | Active-low composite sync |
| line_start_o | output | 1 | One-clock strobe on the first clock of a line |
| frame_start_o | output | 1 | One-clock strobe on the first clock of a frame |

## Verification
The bench probes the clocks on each side of every window edge in both standards. These are the last sync clock and the first clock after it, and the first and last active clocks and their neighbours. A design off by one clock, or one holding the wrong porch, shows a flag one position early or late.

A second instance with short lines and frames measures whole frame periods. It changes the select input partway through a frame. A design that takes the select at any time other than frame start produces a frame of mixed length. One set in that instance has a window longer than its line, and a design without the clip would keep `h_active_o` high into the next line's sync.

An asynchronous reset is applied in mid-run to catch a reset that waits for a clock edge.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef enum logic {
    STD_50HZ = 1'b0,
    STD_60HZ = 1'b1
  } std_sel_e;

  typedef struct packed {
    logic csync_n;
    logic h_act;
    logic v_act;
    logic disp_en;
    logic line_go;
    logic frame_go;
  } raster_flags_t;

  localparam raster_flags_t FLAGS_IDLE = '{csync_n: 1'b1, default: 1'b0};

endpackage

// File: rtl/cs_wrap_counter.sv
module cs_wrap_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         wrap_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         wrap;

  always_comb begin
    wrap  = en_i && (cnt_q >= last_i);
    cnt_d = cnt_q;
    if (en_i) begin
      cnt_d = wrap ? '0 : cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
  assign wrap_o    = wrap;

endmodule

// File: rtl/cs_timing_sel.sv
module cs_timing_sel #(
  parameter int HW             = 12,
  parameter int VW             = 9,
  parameter int HSYNC_CLKS     = 235,
  parameter int VACT_LINES     = 256,
  parameter int S50_LINE       = 3200,
  parameter int S50_BPORCH     = 200,
  parameter int S50_ACTIVE     = 2600,
  parameter int S50_LINES      = 312,
  parameter int S50_VACT_FIRST = 38,
  parameter int S60_LINE       = 3175,
  parameter int S60_BPORCH     = 235,
  parameter int S60_ACTIVE     = 2630,
  parameter int S60_LINES      = 262,
  parameter int S60_VACT_FIRST = 6
) (
  input  logic          sel_i,
  output logic [HW-1:0] h_last_o,
  output logic [HW-1:0] h_act_first_o,
  output logic [HW-1:0] h_act_stop_o,
  output logic [VW-1:0] v_last_o,
  output logic [VW-1:0] v_act_first_o,
  output logic [VW-1:0] v_act_stop_o
);

  localparam int NSTD = 2;
  localparam int LINE_T   [NSTD] = '{S50_LINE, S60_LINE};
  localparam int BP_T     [NSTD] = '{S50_BPORCH, S60_BPORCH};
  localparam int ACT_T    [NSTD] = '{S50_ACTIVE, S60_ACTIVE};
  localparam int LINES_T  [NSTD] = '{S50_LINES, S60_LINES};
  localparam int VFIRST_T [NSTD] = '{S50_VACT_FIRST, S60_VACT_FIRST};

  logic [HW-1:0] h_last_t  [NSTD];
  logic [HW-1:0] h_first_t [NSTD];
  logic [HW-1:0] h_stop_t  [NSTD];
  logic [VW-1:0] v_last_t  [NSTD];
  logic [VW-1:0] v_first_t [NSTD];
  logic [VW-1:0] v_stop_t  [NSTD];

  // One constant set per standard; windows clipped to the line or frame end.
  for (genvar m = 0; m < NSTD; m++) begin : g_std
    localparam int HFIRST = HSYNC_CLKS + BP_T[m];
    localparam int HRAW   = HFIRST + ACT_T[m];
    localparam int HSTOP  = (HRAW > LINE_T[m]) ? LINE_T[m] : HRAW;
    localparam int VRAW   = VFIRST_T[m] + VACT_LINES;
    localparam int VSTOP  = (VRAW > LINES_T[m]) ? LINES_T[m] : VRAW;

    assign h_last_t[m]  = HW'(LINE_T[m] - 1);
    assign h_first_t[m] = HW'(HFIRST);
    assign h_stop_t[m]  = HW'(HSTOP);
    assign v_last_t[m]  = VW'(LINES_T[m] - 1);
    assign v_first_t[m] = VW'(VFIRST_T[m]);
    assign v_stop_t[m]  = VW'(VSTOP);
  end

  assign h_last_o      = h_last_t[sel_i];
  assign h_act_first_o = h_first_t[sel_i];
  assign h_act_stop_o  = h_stop_t[sel_i];
  assign v_last_o      = v_last_t[sel_i];
  assign v_act_first_o = v_first_t[sel_i];
  assign v_act_stop_o  = v_stop_t[sel_i];

endmodule

// File: rtl/cs_raster_decode.sv
module cs_raster_decode
  import cs_pkg::*;
#(
  parameter int HW          = 12,
  parameter int VW          = 9,
  parameter int HSYNC_CLKS  = 235,
  parameter int VSYNC_LINES = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_nxt_i,
  input  logic [VW-1:0] v_nxt_i,
  input  logic [HW-1:0] h_act_first_i,
  input  logic [HW-1:0] h_act_stop_i,
  input  logic [VW-1:0] v_act_first_i,
  input  logic [VW-1:0] v_act_stop_i,
  output raster_flags_t flags_o
);

  localparam logic [HW-1:0] HS_END = HW'(HSYNC_CLKS);
  localparam logic [VW-1:0] VS_END = VW'(VSYNC_LINES);

  raster_flags_t flags_d;
  raster_flags_t flags_q;
  logic          hs_n;
  logic          vs_n;

  // Decode the count the counters are about to take, so flags line up with them.
  always_comb begin
    hs_n             = (h_nxt_i >= HS_END);
    vs_n             = (v_nxt_i >= VS_END);
    flags_d.csync_n  = hs_n & vs_n;
    flags_d.h_act    = (h_nxt_i >= h_act_first_i) && (h_nxt_i < h_act_stop_i);
    flags_d.v_act    = (v_nxt_i >= v_act_first_i) && (v_nxt_i < v_act_stop_i);
    flags_d.disp_en  = flags_d.h_act & flags_d.v_act;
    flags_d.line_go  = (h_nxt_i == '0);
    flags_d.frame_go = (h_nxt_i == '0) && (v_nxt_i == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= FLAGS_IDLE;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/comp_sync_gen.sv
module comp_sync_gen
  import cs_pkg::*;
#(
  parameter int HW             = 12,
  parameter int VW             = 9,
  parameter int HSYNC_CLKS     = 235,
  parameter int VSYNC_LINES    = 5,
  parameter int VACT_LINES     = 256,
  parameter int S50_LINE       = 3200,
  parameter int S50_BPORCH     = 200,
  parameter int S50_ACTIVE     = 2600,
  parameter int S50_LINES      = 312,
  parameter int S50_VACT_FIRST = 38,
  parameter int S60_LINE       = 3175,
  parameter int S60_BPORCH     = 235,
  parameter int S60_ACTIVE     = 2630,
  parameter int S60_LINES      = 262,
  parameter int S60_VACT_FIRST = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          std_sel_i,
  output logic [HW-1:0] h_cnt_o,
  output logic [VW-1:0] v_cnt_o,
  output logic          h_active_o,
  output logic          v_active_o,
  output logic          disp_en_o,
  output logic          csync_n_o,
  output logic          line_start_o,
  output logic          frame_start_o
);

  std_sel_e      std_q;
  std_sel_e      std_d;
  logic          std_load;

  logic [HW-1:0] h_cnt, h_nxt, h_last, h_first, h_stop;
  logic [VW-1:0] v_cnt, v_nxt, v_last, v_first, v_stop;
  logic          h_wrap;
  logic          v_wrap_unused;
  raster_flags_t flags;

  // The standard is taken only on the first clock of a frame.
  always_comb begin
    std_load = (h_cnt == '0) && (v_cnt == '0);
    std_d    = std_load ? std_sel_e'(std_sel_i) : std_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_q <= STD_50HZ;
    end else if (std_load) begin
      std_q <= std_d;
    end
  end

  // std_d differs from std_q only at position (0,0), where no wrap compare
  // can fire, so one table driven by std_d serves counters and decode.
  cs_timing_sel #(
    .HW(HW), .VW(VW), .HSYNC_CLKS(HSYNC_CLKS), .VACT_LINES(VACT_LINES),
    .S50_LINE(S50_LINE), .S50_BPORCH(S50_BPORCH), .S50_ACTIVE(S50_ACTIVE),
    .S50_LINES(S50_LINES), .S50_VACT_FIRST(S50_VACT_FIRST),
    .S60_LINE(S60_LINE), .S60_BPORCH(S60_BPORCH), .S60_ACTIVE(S60_ACTIVE),
    .S60_LINES(S60_LINES), .S60_VACT_FIRST(S60_VACT_FIRST)
  ) u_tsel (
    .sel_i         (std_d),
    .h_last_o      (h_last),
    .h_act_first_o (h_first),
    .h_act_stop_o  (h_stop),
    .v_last_o      (v_last),
    .v_act_first_o (v_first),
    .v_act_stop_o  (v_stop)
  );

  cs_wrap_counter #(.W(HW)) u_hcnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (1'b1),
    .last_i    (h_last),
    .cnt_o     (h_cnt),
    .cnt_nxt_o (h_nxt),
    .wrap_o    (h_wrap)
  );

  cs_wrap_counter #(.W(VW)) u_vcnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (h_wrap),
    .last_i    (v_last),
    .cnt_o     (v_cnt),
    .cnt_nxt_o (v_nxt),
    .wrap_o    (v_wrap_unused)
  );

  cs_raster_decode #(
    .HW(HW), .VW(VW), .HSYNC_CLKS(HSYNC_CLKS), .VSYNC_LINES(VSYNC_LINES)
  ) u_dec (
    .clk           (clk),
    .rst_n         (rst_n),
    .h_nxt_i       (h_nxt),
    .v_nxt_i       (v_nxt),
    .h_act_first_i (h_first),
    .h_act_stop_i  (h_stop),
    .v_act_first_i (v_first),
    .v_act_stop_i  (v_stop),
    .flags_o       (flags)
  );

  assign h_cnt_o       = h_cnt;
  assign v_cnt_o       = v_cnt;
  assign h_active_o    = flags.h_act;
  assign v_active_o    = flags.v_act;
  assign disp_en_o     = flags.disp_en;
  assign csync_n_o     = flags.csync_n;
  assign line_start_o  = flags.line_go;
  assign frame_start_o = flags.frame_go;

endmodule

// File: rtl/cs_sync_chk.sv
module cs_sync_chk #(
  parameter int HW          = 12,
  parameter int VW          = 9,
  parameter int HSYNC_CLKS  = 235,
  parameter int VSYNC_LINES = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          std_q,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt,
  input logic          h_act,
  input logic          v_act,
  input logic          disp_en,
  input logic          csync_n,
  input logic          line_start,
  input logic          frame_start
);

  localparam logic [HW-1:0] HS_END = HW'(HSYNC_CLKS);
  localparam logic [VW-1:0] VS_END = VW'(VSYNC_LINES);

  logic live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
    end
  end

  // R2
  hcount_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt != '0) |-> (h_cnt == HW'($past(h_cnt) + 1'b1)));

  // R2
  vcount_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt != '0) |-> $stable(v_cnt));

  // R4
  hsync_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && (h_cnt < HS_END)) |-> !csync_n);

  // R5
  vsync_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && (v_cnt < VS_END)) |-> !csync_n);

  // R5
  sync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && (h_cnt >= HS_END) && (v_cnt >= VS_END)) |-> csync_n);

  // R6
  hact_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_act |-> (h_cnt >= HS_END));

  // R7
  vact_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_act |-> (v_cnt >= VS_END));

  // R8
  de_no_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (csync_n && !line_start));

  // R9
  line_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

  // R9
  frame_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (line_start && (h_cnt == '0) && (v_cnt == '0)));

  // R10
  std_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((h_cnt == '0) && (v_cnt == '0)) |=> $stable(std_q));

endmodule

bind comp_sync_gen cs_sync_chk #(
  .HW(HW), .VW(VW), .HSYNC_CLKS(HSYNC_CLKS), .VSYNC_LINES(VSYNC_LINES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .std_q       (std_q),
  .h_cnt       (h_cnt_o),
  .v_cnt       (v_cnt_o),
  .h_act       (h_active_o),
  .v_act       (v_active_o),
  .disp_en     (disp_en_o),
  .csync_n     (csync_n_o),
  .line_start  (line_start_o),
  .frame_start (frame_start_o)
);

// File: tb/comp_sync_gen_tb_top.sv
module comp_sync_gen_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Full-size instance
  logic        rst_n = 1'b0;
  logic        mode  = 1'b0;
  logic [11:0] h;
  logic [8:0]  v;
  logic        ha, va, de, cs, ls, fs;

  comp_sync_gen dut_i (
    .clk(clk), .rst_n(rst_n), .std_sel_i(mode),
    .h_cnt_o(h), .v_cnt_o(v), .h_active_o(ha), .v_active_o(va),
    .disp_en_o(de), .csync_n_o(cs), .line_start_o(ls), .frame_start_o(fs)
  );

  // Scaled instance: 40x12 and 30x10 rasters; the 60 Hz window overruns its line
  logic        rst_s_n = 1'b0;
  logic        mode_s  = 1'b0;
  logic [11:0] hs;
  logic [8:0]  vs;
  logic        has, vas, des, css, lss, fss;

  comp_sync_gen #(
    .HSYNC_CLKS(4), .VSYNC_LINES(2), .VACT_LINES(6),
    .S50_LINE(40), .S50_BPORCH(3), .S50_ACTIVE(30), .S50_LINES(12), .S50_VACT_FIRST(4),
    .S60_LINE(30), .S60_BPORCH(4), .S60_ACTIVE(30), .S60_LINES(10), .S60_VACT_FIRST(3)
  ) small_i (
    .clk(clk), .rst_n(rst_s_n), .std_sel_i(mode_s),
    .h_cnt_o(hs), .v_cnt_o(vs), .h_active_o(has), .v_active_o(vas),
    .disp_en_o(des), .csync_n_o(css), .line_start_o(lss), .frame_start_o(fss)
  );

  typedef struct packed {
    logic        m;
    logic [11:0] h;
    logic [8:0]  v;
    logic        cs;
    logic        ha;
    logic        va;
    logic        de;
    logic        ls;
    logic        fs;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    // 50 Hz set
    '{1'b0, 12'd1,    9'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 12'd234,  9'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 12'd235,  9'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 12'd0,    9'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b0, 12'd234,  9'd5,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 12'd235,  9'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 12'd435,  9'd5,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 12'd435,  9'd37, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 12'd0,    9'd38, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b0, 12'd434,  9'd38, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 12'd435,  9'd38, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 12'd3034, 9'd38, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 12'd3035, 9'd38, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 12'd3199, 9'd38, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    // 60 Hz set
    '{1'b1, 12'd1,    9'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 12'd0,    9'd4,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b1, 12'd235,  9'd4,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 12'd235,  9'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 12'd469,  9'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 12'd470,  9'd5,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 12'd3099, 9'd5,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 12'd3100, 9'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 12'd3174, 9'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 12'd0,    9'd6,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b1, 12'd470,  9'd6,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reset_dut(input logic m);
    @(negedge clk);
    rst_n = 1'b0;
    mode  = m;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "h count in reset", int'(h), 0);
    chk("R1", "v count in reset", int'(v), 0);
    chk("R1", "csync in reset", int'(cs), 1);
    chk("R1", "flags in reset", int'({ha, va, de, ls, fs}), 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_dut(input int th, input int tv);
    while (!(int'(h) == th && int'(v) == tv)) @(negedge clk);
  endtask

  task automatic wait_small(input int th, input int tv);
    while (!(int'(hs) == th && int'(vs) == tv)) @(negedge clk);
  endtask

  // Clocks from one frame_start strobe to the next, starting on a strobe.
  task automatic small_frame_len(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fss);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;

    // ---- scaled instance: frame lengths, select timing, clipping ----
    mode_s = 1'b0;
    repeat (3) @(negedge clk);
    rst_s_n = 1'b1;
    while (!fss) @(negedge clk);
    @(negedge clk);
    // R9: one-clock strobe
    chk("R9", "frame strobe width", int'(fss), 0);
    while (!fss) @(negedge clk);
    small_frame_len(n);
    chk("R3", "50 Hz frame length (scaled 40x12)", n, 480);
    // R10: change select mid-frame; current frame must keep its length
    repeat (100) @(negedge clk);
    mode_s = 1'b1;
    n = 100;
    do begin
      @(negedge clk);
      n++;
    end while (!fss);
    chk("R10", "frame length with mid-frame select change", n, 480);
    small_frame_len(n);
    chk("R3", "60 Hz frame length (scaled 30x10)", n, 300);
    // R6: window 8..37 is clipped to the 30-clock line
    wait_small(7, 4);
    chk("R6", "scaled h_active before start", int'(has), 0);
    wait_small(8, 4);
    chk("R6", "scaled h_active at start", int'(has), 1);
    chk("R8", "scaled display enable", int'(des), 1);
    wait_small(29, 4);
    chk("R6", "scaled h_active at line end", int'(has), 1);
    @(negedge clk);
    chk("R6", "scaled h_active clipped at next line", int'(has), 0);
    chk("R2", "scaled line advance", int'(vs), 5);
    // R7: window lines 3..8
    wait_small(10, 8);
    chk("R7", "scaled v_active last line", int'(vas), 1);
    wait_small(10, 9);
    chk("R7", "scaled v_active after window", int'(vas), 0);
    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_s_n = 1'b0;
    #1;
    chk("R1", "async reset h count", int'(hs), 0);
    chk("R1", "async reset csync", int'(css), 1);
    chk("R1", "async reset flags", int'({has, vas, des, lss, fss}), 0);

    // ---- full-size instance: vector table ----
    for (int i = 0; i < NV; i++) begin
      if (i == 0 || VECS[i].m != VECS[i-1].m) reset_dut(VECS[i].m);
      wait_dut(int'(VECS[i].h), int'(VECS[i].v));
      // R11: flags aligned with the counts shown
      chk("R5", $sformatf("csync at v%0d h%0d", VECS[i].v, VECS[i].h), int'(cs), int'(VECS[i].cs));
      chk("R6", $sformatf("h_active at v%0d h%0d", VECS[i].v, VECS[i].h), int'(ha), int'(VECS[i].ha));
      chk("R7", $sformatf("v_active at v%0d h%0d", VECS[i].v, VECS[i].h), int'(va), int'(VECS[i].va));
      chk("R8", $sformatf("disp_en at v%0d h%0d", VECS[i].v, VECS[i].h), int'(de), int'(VECS[i].de));
      chk("R9", $sformatf("line_start at v%0d h%0d", VECS[i].v, VECS[i].h), int'(ls), int'(VECS[i].ls));
      chk("R9", $sformatf("frame_start at v%0d h%0d", VECS[i].v, VECS[i].h), int'(fs), int'(VECS[i].fs));
    end

    // R2: 60 Hz line length (instance still in 60 Hz set)
    while (!ls) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ls);
    chk("R2", "60 Hz line length", n, 3175);
    chk("R2", "line number after two starts", int'(v), 8);

    // R2: 50 Hz line length; R9: no strobe right after reset
    reset_dut(1'b0);
    @(negedge clk);
    chk("R9", "no line strobe after reset", int'(ls), 0);
    while (!ls) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ls);
    chk("R2", "50 Hz line length", n, 3200);
    chk("R2", "line number after two starts", int'(v), 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule